// File: doc/BRIEF.md
# Gated Bit-Error Counter with Error Strobe and Pattern Trigger

This block is the counting core of a bit-error-rate receiver. Each accepted beat carries one received bit and the bit the local reference pattern expects at the same position. The block decides whether the beat takes part in the measurement. If it does, it adds one to a compared-bit counter, and it adds one to an error counter when the two bits differ. A gate input controls which beats are measured. Its meaning depends on the mode pin.

In continuous mode, raising the gate removes beats from the measurement in whole granules of 512 beats. In burst mode, the gate marks out bursts. While the gate is low a burst is in progress. Every burst first spends 1536 beats on synchronisation, and only the beats after that are compared. When the gate rises, 1536 backlash beats are thrown away. A gate that stays high for fewer than 2560 beats before it falls again sets a sticky timing-violation flag.

Two outputs support external instruments. The error strobe shows, for a whole 128-beat segment, whether the segment before it held any error. The trigger output has two modes. In the first it gives a one-cycle pulse on every fourth pattern start. In the second it is a square wave at the clock rate divided by a selectable power of two.

Top module: `bert_err_detect`

## Requirements
- R1: In continuous mode (`burst_mode`=0), a valid beat with `gate`=1 starts an exclusion of exactly 512 valid beats, that beat included. If `gate` is still 1 on the first beat after the exclusion, a further 512-beat exclusion starts. Excluded beats are not counted.
- R2: In burst mode (`burst_mode`=1), a burst starts on the first valid beat with `gate`=0 once no backlash is pending. That beat and the next 1535 valid beats with `gate`=0 are synchronisation beats and are not counted. Later valid beats with `gate`=0 are counted.
- R3: In burst mode, the valid beat on which `gate` is 1 during a burst ends the burst. That beat and the next 1535 valid beats are backlash beats. Backlash beats are never counted, and a burst cannot start during backlash, even if `gate` is 0.
- R4: In burst mode, a valid beat with `gate`=0 outside a burst sets `gate_violation` if fewer than 2560 valid passive beats have passed since the previous burst ended. The flag then stays at 1 until `clear`. After reset, or after continuous mode, the passive window counts as already met.
- R5: Each counted beat adds one to `bit_count`. A counted beat with `s_rx` different from `s_ref` also adds one to `err_count`. Both counters are `CNT_W` bits wide (default 48) and stop at all ones.
- R6: `clear`=1 sets `err_count`, `bit_count` and `gate_violation` to 0 in the next cycle.
- R7: Valid beats are grouped into consecutive segments of 128, starting from reset. At the last beat of each segment, `err_out` takes the OR of the errors counted in that segment, and it holds that value until the last beat of the next segment.
- R8: With `trig_div_mode`=0, `trig_out` is 1 for exactly one cycle after every fourth valid beat that has `s_pat_start`=1 (the 4th, 8th and so on since reset). Otherwise it is 0.
- R9: With `trig_div_mode`=1, `trig_out` is a square wave that toggles every 2<<k clock cycles, so its period is 4<<k cycles. Here k = `div_sel`, limited to at most 4, which gives division factors 4, 8, 16, 32 and 64.
- R10: `s_ready` is 1 whenever the block is out of reset, so the block never applies back-pressure. A cycle with `s_valid`=0 changes no counter, segment, gating or trigger-pattern state.
- R11: After reset, both counters, `err_out`, `trig_out` and `gate_violation` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Beat valid |
| s_ready | output | 1 | Beat accepted; constant 1 out of reset |
| s_rx | input | 1 | Received bit |
| s_ref | input | 1 | Expected reference bit |
| s_pat_start | input | 1 | Beat is the first bit of a pattern repetition |
| gate | input | 1 | Gate: mask request (continuous) or burst delimiter (burst, low = burst) |
| burst_mode | input | 1 | 0 = continuous gating, 1 = burst gating |
| clear | input | 1 | Zero the counters and the violation flag |
| trig_div_mode | input | 1 | 0 = pattern trigger, 1 = divided-clock square wave |
| div_sel | input | 3 | Divider select k, division 4<<min(k,4) |
| err_count | output | CNT_W | Saturating count of errored compared beats |
| bit_count | output | CNT_W | Saturating count of compared beats |
| err_out | output | 1 | Error strobe held for a segment |
| trig_out | output | 1 | Trigger output |
| gate_violation | output | 1 | Sticky gate-passive-time violation |

## Verification
The hardest state to reach is the interplay between backlash and the passive window. A gate that falls in the middle of backlash has to raise the flag and also hold back the start of synchronisation until backlash ends. Reaching it takes thousands of beats in a precise order. The stimulus therefore runs a sequence of bursts with random high and low lengths. Some high lengths are chosen shorter than the backlash, some fall between the backlash and the passive limit, and some are legal. Idle cycles with `s_valid` low are mixed in, and a bench model tracks the expected counts.

// File: rtl/ed_pkg.sv
package ed_pkg;
  typedef enum logic [1:0] {
    BS_PASSIVE = 2'd0,
    BS_SYNC    = 2'd1,
    BS_CHECK   = 2'd2
  } bstate_t;
endpackage

// File: rtl/ed_gate_ctrl.sv
module ed_gate_ctrl
  import ed_pkg::*;
#(
  parameter int GRAN          = 512,
  parameter int SYNC_BITS     = 1536,
  parameter int BACKLASH_BITS = 1536,
  parameter int PASSIVE_BITS  = 2560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic gate,
  input  logic burst_mode,
  input  logic clear,
  output logic cmp_en,
  output logic violation
);
  localparam int GW = $clog2(GRAN);
  localparam int SW = $clog2(SYNC_BITS + 1);
  localparam int BW = $clog2(BACKLASH_BITS + 1);
  localparam int PW = $clog2(PASSIVE_BITS + 1);

  logic [GW-1:0] ex_rem;
  logic          excl_c;
  bstate_t       st;
  logic [SW-1:0] sync_rem;
  logic [BW-1:0] bl_rem;
  logic [PW-1:0] gap;

  assign excl_c = (ex_rem != '0) || gate;

  always_ff @(posedge clk) begin
    if (!rst_n || burst_mode) begin
      ex_rem <= '0;
    end else if (beat) begin
      if (ex_rem != '0)  ex_rem <= ex_rem - 1'b1;
      else if (gate)     ex_rem <= GW'(GRAN - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= BS_PASSIVE;
      sync_rem  <= '0;
      bl_rem    <= '0;
      gap       <= PW'(PASSIVE_BITS);
      violation <= 1'b0;
    end else begin
      if (clear) violation <= 1'b0;
      if (!burst_mode) begin
        st     <= BS_PASSIVE;
        bl_rem <= '0;
        gap    <= PW'(PASSIVE_BITS);
      end else if (beat) begin
        case (st)
          BS_PASSIVE: begin
            if (gap != PW'(PASSIVE_BITS)) gap <= gap + 1'b1;
            if (!gate && gap != PW'(PASSIVE_BITS)) violation <= 1'b1;
            if (bl_rem != '0) begin
              bl_rem <= bl_rem - 1'b1;
            end else if (!gate) begin
              st       <= BS_SYNC;
              sync_rem <= SW'(SYNC_BITS - 1);
            end
          end
          BS_SYNC, BS_CHECK: begin
            if (gate) begin
              st     <= BS_PASSIVE;
              bl_rem <= BW'(BACKLASH_BITS - 1);
              gap    <= PW'(1);
            end else if (st == BS_SYNC) begin
              sync_rem <= sync_rem - 1'b1;
              if (sync_rem == SW'(1)) st <= BS_CHECK;
            end
          end
          default: st <= BS_PASSIVE;
        endcase
      end
    end
  end

  assign cmp_en = beat && (burst_mode ? (st == BS_CHECK && !gate) : !excl_c);

  AST_BURST_CMP_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode && cmp_en |-> !gate); // R2
  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !clear |=> violation); // R4
endmodule

// File: rtl/ed_sat_cnt.sv
module ed_sat_cnt #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear)       q <= '0;
    else if (inc && q != '1)   q <= q + 1'b1;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q == '1) && !clear |=> (q == '1)); // R5
endmodule

// File: rtl/ed_err_seg.sv
module ed_err_seg #(
  parameter int SEG = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic err,
  output logic err_out
);
  localparam int CW = $clog2(SEG);

  logic [CW-1:0] seg_cnt;
  logic          acc;
  logic          seg_last;

  assign seg_last = (seg_cnt == CW'(SEG - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_cnt <= '0;
      acc     <= 1'b0;
      err_out <= 1'b0;
    end else if (beat) begin
      if (seg_last) begin
        err_out <= acc | err;
        acc     <= 1'b0;
        seg_cnt <= '0;
      end else begin
        acc     <= acc | err;
        seg_cnt <= seg_cnt + 1'b1;
      end
    end
  end

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && seg_last) |=> $stable(err_out)); // R7
endmodule

// File: rtl/ed_trigger.sv
module ed_trigger #(
  parameter int REP         = 4,
  parameter int DIV_MAX_SEL = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       pat_start,
  input  logic       div_mode,
  input  logic [2:0] div_sel,
  output logic       trig
);
  localparam int RW = (REP > 1) ? $clog2(REP) : 1;
  localparam int HW = DIV_MAX_SEL + 2;

  logic [RW-1:0] rep_cnt;
  logic          pulse;
  logic [HW-1:0] half_cnt;
  logic [HW-1:0] half_m1;
  logic [2:0]    sel_c;
  logic          sq;

  assign sel_c   = (div_sel > 3'(DIV_MAX_SEL)) ? 3'(DIV_MAX_SEL) : div_sel;
  assign half_m1 = (HW'(2) << sel_c) - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_cnt <= '0;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (beat && pat_start) begin
        if (rep_cnt == RW'(REP - 1)) begin
          rep_cnt <= '0;
          pulse   <= 1'b1;
        end else begin
          rep_cnt <= rep_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !div_mode) begin
      half_cnt <= '0;
      sq       <= 1'b0;
    end else if (half_cnt == half_m1) begin
      half_cnt <= '0;
      sq       <= ~sq;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  assign trig = div_mode ? sq : pulse;

  AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R8
endmodule

// File: rtl/bert_err_detect.sv
module bert_err_detect #(
  parameter int CNT_W         = 48,
  parameter int GRAN          = 512,
  parameter int SYNC_BITS     = 1536,
  parameter int BACKLASH_BITS = 1536,
  parameter int PASSIVE_BITS  = 2560,
  parameter int SEG           = 128,
  parameter int TRIG_REP      = 4,
  parameter int DIV_MAX_SEL   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_rx,
  input  logic             s_ref,
  input  logic             s_pat_start,
  input  logic             gate,
  input  logic             burst_mode,
  input  logic             clear,
  input  logic             trig_div_mode,
  input  logic [2:0]       div_sel,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic             err_out,
  output logic             trig_out,
  output logic             gate_violation
);
  logic cmp_en;
  logic is_err;

  assign s_ready = 1'b1;
  assign is_err  = cmp_en && (s_rx ^ s_ref);

  ed_gate_ctrl #(
    .GRAN(GRAN), .SYNC_BITS(SYNC_BITS),
    .BACKLASH_BITS(BACKLASH_BITS), .PASSIVE_BITS(PASSIVE_BITS)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .beat(s_valid), .gate(gate),
    .burst_mode(burst_mode), .clear(clear),
    .cmp_en(cmp_en), .violation(gate_violation)
  );

  for (genvar i = 0; i < 2; i++) begin : g_cnt
    logic [CNT_W-1:0] q;
    ed_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .inc((i == 0) ? cmp_en : is_err), .q(q)
    );
  end
  assign bit_count = g_cnt[0].q;
  assign err_count = g_cnt[1].q;

  ed_err_seg #(.SEG(SEG)) u_seg (
    .clk(clk), .rst_n(rst_n), .beat(s_valid), .err(is_err), .err_out(err_out)
  );

  ed_trigger #(.REP(TRIG_REP), .DIV_MAX_SEL(DIV_MAX_SEL)) u_trig (
    .clk(clk), .rst_n(rst_n), .beat(s_valid), .pat_start(s_pat_start),
    .div_mode(trig_div_mode), .div_sel(div_sel), .trig(trig_out)
  );

  AST_ERR_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= bit_count); // R5
  AST_CONT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_mode && s_valid && gate && !clear |=> $stable(bit_count)); // R1
  AST_BURST_GATE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode && s_valid && gate && !clear |=> $stable(bit_count)); // R3
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid && !clear |=> $stable(bit_count) && $stable(err_count)); // R10
endmodule

// File: tb/bert_err_detect_test.sv
module bert_err_detect_test;
  localparam int GRAN = 512, SYNC = 1536, BACKL = 1536, PASSIVE = 2560, SEG = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 0, s_rx = 0, s_ref = 0, s_pat_start = 0, gate = 0;
  logic burst_mode = 0, clear = 0, trig_div_mode = 0;
  logic [2:0] div_sel = 0;
  logic s_ready, err_out, trig_out, gate_violation;
  logic [47:0] err_count, bit_count;
  logic s_ready2, err_out2, trig_out2, viol2;
  logic [3:0] err_small, bit_small;

  always #2.5 clk = ~clk;

  bert_err_detect uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_rx(s_rx),
    .s_ref(s_ref), .s_pat_start(s_pat_start), .gate(gate), .burst_mode(burst_mode),
    .clear(clear), .trig_div_mode(trig_div_mode), .div_sel(div_sel),
    .err_count(err_count), .bit_count(bit_count), .err_out(err_out),
    .trig_out(trig_out), .gate_violation(gate_violation)
  );

  bert_err_detect #(.CNT_W(4)) uut_sat (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready2), .s_rx(s_rx),
    .s_ref(s_ref), .s_pat_start(s_pat_start), .gate(gate), .burst_mode(burst_mode),
    .clear(clear), .trig_div_mode(trig_div_mode), .div_sel(div_sel),
    .err_count(err_small), .bit_count(bit_small), .err_out(err_out2),
    .trig_out(trig_out2), .gate_violation(viol2)
  );

  int vectors = 0, fails = 0;
  bit done = 0;

  // bench model state
  longint m_bits = 0, m_errs = 0;
  int ex_left = 0;
  bit in_burst = 0;
  int sync_cnt = 0, since_rise = 1 << 20;
  bit m_viol = 0;
  int seg_n = 0;
  bit seg_acc = 0, m_err_out = 0;
  int rep = 0;
  bit m_trig = 0;
  int pat_pos = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sat15(input longint v);
    return (v > 15) ? 15 : v;
  endfunction

  task automatic check_all();
    chk("R5 bit_count", bit_count, m_bits);
    chk("R5 err_count", err_count, m_errs);
    chk("R5 saturated bit_count", bit_small, sat15(m_bits));
    chk("R5 saturated err_count", err_small, sat15(m_errs));
    chk("R4 gate_violation", gate_violation, m_viol);
    chk("R7 err_out", err_out, m_err_out);
    if (!trig_div_mode) chk("R8 trig_out", trig_out, m_trig);
    chk("R10 s_ready", s_ready, 1);
  endtask

  // one clock: check outputs from the previous edge, drive, advance the model
  task automatic step(input bit v, input bit rx, input bit rf, input bit g, input bit cl);
    bit ps, cmp, e;
    @(negedge clk);
    check_all();
    ps = v && (pat_pos == 0);
    s_valid = v; s_rx = rx; s_ref = rf; gate = g; clear = cl; s_pat_start = ps;
    if (v) pat_pos = (pat_pos == 99) ? 0 : pat_pos + 1;
    cmp = 0;
    if (!burst_mode) begin
      in_burst = 0; since_rise = 1 << 20;
      if (v) begin
        cmp = !(ex_left > 0 || g);
        if (ex_left > 0) ex_left--;
        else if (g) ex_left = GRAN - 1;
      end
    end else begin
      ex_left = 0;
      if (v) begin
        if (g) begin
          if (in_burst) begin in_burst = 0; since_rise = 1; end
          else since_rise++;
        end else if (!in_burst) begin
          if (since_rise < PASSIVE) m_viol = 1;
          if (since_rise >= BACKL) begin in_burst = 1; sync_cnt = 1; end
          since_rise++;
        end else if (sync_cnt < SYNC) sync_cnt++;
        else cmp = 1;
      end
    end
    e = cmp && (rx != rf);
    if (cl) begin m_bits = 0; m_errs = 0; m_viol = 0; end
    else begin
      if (cmp) m_bits++;
      if (e) m_errs++;
    end
    m_trig = 0;
    if (v) begin
      if (seg_n == SEG - 1) begin m_err_out = seg_acc | e; seg_acc = 0; seg_n = 0; end
      else begin seg_acc = seg_acc | e; seg_n++; end
      if (ps) begin
        if (rep == 3) begin rep = 0; m_trig = 1; end else rep++;
      end
    end
  endtask

  task automatic rbeat(input bit g, input int err_mod);
    bit v, rx, rf;
    v  = ($urandom % 16) != 0;
    rf = $urandom % 2;
    rx = (($urandom % err_mod) == 0) ? ~rf : rf;
    step(v, rx, rf, g, 0);
  endtask

  task automatic do_clear();
    step(0, 0, 0, gate, 1);
    step(0, 0, 0, gate, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd31415));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 err_count", err_count, 0);
    chk("R11 bit_count", bit_count, 0);
    chk("R11 err_out", err_out, 0);
    chk("R11 trig_out", trig_out, 0);
    chk("R11 gate_violation", gate_violation, 0);

    // R1 directed: one gated beat masks 512 beats
    step(1, 1, 0, 1, 0);
    for (int i = 0; i < 600; i++) step(1, i[0], 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R1 granule", bit_count, 600 - (GRAN - 1));
    // R1 gate held across a granule edge gives two granules
    do_clear();
    for (int i = 0; i < 513; i++) step(1, 0, 0, 1, 0);
    for (int i = 0; i < 1100; i++) step(1, 1, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R1 two granules", bit_count, 1100 - (2 * GRAN - 513));

    // R5/R7/R8/R10 continuous random with idle cycles
    for (int i = 0; i < 12000; i++) begin
      int len = 1 + $urandom % 40;
      bit g = ($urandom % 20) == 0;
      for (int j = 0; j < len && i < 12000; j++) begin rbeat(g, (i < 6000) ? 9 : 200); i++; end
    end

    // R6 clear
    do_clear();
    chk("R6 counts cleared", bit_count, 0);

    // burst mode
    @(negedge clk); burst_mode = 1;
    // R2 directed: legal passive gap, then burst of 4000 beats
    for (int i = 0; i < 3000; i++) step(1, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) step(1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R2 sync then count", bit_count, 4000 - SYNC);
    // R3 directed: short high during backlash defers the next burst
    do_clear();
    for (int i = 0; i < 100; i++) step(1, 0, 0, 1, 0);
    for (int i = 0; i < 4000; i++) step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R3 backlash deferral", bit_count, 4000 - (BACKL - 100) - SYNC);
    chk("R4 violation set", gate_violation, 1);
    do_clear();
    chk("R6 violation cleared", gate_violation, 0);

    // R2/R3/R4 random bursts
    for (int b = 0; b < 10; b++) begin
      int hi, lo, sel;
      sel = $urandom % 3;
      hi = (sel == 0) ? 200 + $urandom % 1200 : (sel == 1) ? 1600 + $urandom % 900 : 2600 + $urandom % 800;
      lo = 300 + $urandom % 3500;
      for (int i = 0; i < hi; i++) rbeat(1, 7);
      for (int i = 0; i < lo; i++) rbeat(0, 7);
      if (b == 4) do_clear();
    end
    step(0, 0, 0, 1, 0);
    @(negedge clk); burst_mode = 0;
    step(0, 0, 0, 0, 0);

    // R9 divided clock
    for (int s = 0; s < 6; s++) begin
      int half, last, cnt;
      logic prev;
      @(negedge clk); trig_div_mode = 1; div_sel = 3'(s);
      half = 2 << ((s > 4) ? 4 : s);
      repeat (3) @(negedge clk);
      prev = trig_out; last = -1; cnt = 0;
      for (int c = 0; c < 8 * half; c++) begin
        @(negedge clk);
        if (trig_out != prev) begin
          if (last >= 0) chk("R9 half period", c - last, half);
          last = c;
        end
        prev = trig_out;
      end
      @(negedge clk); trig_div_mode = 0;
    end
    step(0, 0, 0, 0, 0);
    check_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule